// File: doc/BRIEF.md
# Dual-Mode Accumulator Phase Detector

This block is the digital phase-detection front end of an all-digital PLL. It runs in the reference clock domain. Every reference cycle it adds the programmed multiplication factor, scaled down by the prescaler ratio of four, into a fixed-point reference phase accumulator. It samples an already-synchronized running count of prescaler output edges as the oscillator phase. The integer part of the reference phase minus that sample gives a signed phase error. The subtraction is done modulo 2^W, so counters that wrap never produce a false large error.

During frequency acquisition the block sends out the full signed error (linear mode). During phase tracking it sends out only a sign, +1 or -1 (binary mode). A built-in lock monitor with hysteresis moves between the two modes. It enters tracking once the error magnitude has stayed small for a programmed number of consecutive cycles. It falls back to linear mode when the magnitude exceeds a second, larger threshold. A mode-status output and a one-cycle change pulse let a downstream loop filter swap its gains on the same edge as the output format changes.

Top module: `phase_det_dual`

## Requirements
- R1: A synchronous reset, seen on a clock edge, clears both accumulators and the lock counter and forces linear mode. After that edge err_out is 0 and err_valid, mode_track and mode_chg are 0.
- R2: mult_n is an unsigned value with 2 fractional bits (it equals N, read as N/4). Each cycle out of reset it is added modulo 2^(W+2) into the reference accumulator. Only bits [W+1:2] of the accumulator take part in the error.
- R3: osc_count is registered on every edge. The error formed at edge k equals (reference integer after edge k-1) minus (osc_count sampled at edge k-1), taken modulo 2^W and read as two's complement. It appears on err_out after edge k.
- R4: In linear mode (mode_track = 0), err_out carries the full W-bit signed error.
- R5: In tracking mode (mode_track = 1), err_out is +1 when the error is zero or positive and -1 (all ones) when it is negative.
- R6: In linear mode, an evaluation with |error| <= lock_thr adds one to the run of consecutive good evaluations, and any other evaluation restarts the run at zero. The evaluation that brings the run to lock_len switches to tracking, and a lock_len of 0 acts as 1.
- R7: In tracking mode, an evaluation with |error| > unlock_thr returns the block to linear mode with a zero run. A magnitude at or below unlock_thr keeps tracking.
- R8: mode_chg is high for exactly the one cycle after the edge on which mode_track changes. On that edge err_out already uses the format of the new mode.
- R9: err_valid is high after every edge that is taken out of reset.
- R10: Accumulator wraparound is seamless. Error magnitudes up to 2^(W-1) are reported correctly, whatever the absolute counter values are, and the most negative code gives magnitude 2^(W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| mult_n | input | W+2 | Multiplication factor N (N/4 with 2 fractional bits) |
| osc_count | input | W | Synchronized prescaler edge count |
| lock_thr | input | W | Magnitude limit for counting toward lock |
| unlock_thr | input | W | Magnitude above which tracking is dropped |
| lock_len | input | CW | Consecutive good cycles needed to lock |
| err_out | output | W | Signed error, or ±1 in tracking mode |
| err_valid | output | 1 | High once per reference cycle with fresh err_out |
| mode_track | output | 1 | 1 = binary tracking mode, 0 = linear mode |
| mode_chg | output | 1 | One-cycle pulse on each mode change |

## Verification
Every output is registered once, so err_out, err_valid, mode_track and mode_chg reflect the inputs held before the previous edge. A change on osc_count or mult_n therefore shows in err_out two edges later. The bench drives all inputs on the falling edge and advances its arithmetic model on the rising edge, using the inputs held there. It compares all four outputs on the next falling edge, so each expected value sits in the cycle where the register chain delivers it. To aim an exact error at a chosen edge, the bench sets osc_count to the integer part of its own accumulator plus mult_n, minus the wanted error. That places each threshold and run-length boundary precisely.

// File: rtl/pdet_pkg.sv
package pdet_pkg;

   typedef enum logic {
      MODE_LINEAR = 1'b0,
      MODE_TRACK  = 1'b1
   } pd_mode_e;

   function automatic int unsigned clog2_min1(input int unsigned v);
      int unsigned r;
      r = 1;
      while ((1 << r) < v) r++;
      return r;
   endfunction

endpackage

// File: rtl/pdet_ref_acc.sv
module pdet_ref_acc #(
   parameter int W    = 8,
   parameter int FRAC = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [W+FRAC-1:0] n_step,
   output logic [W-1:0]      acc_int
);
   localparam int AW = W + FRAC;

   logic [AW-1:0] acc_q;

   always_ff @(posedge clk) begin
      if (rst) acc_q <= '0;
      else     acc_q <= acc_q + n_step;
   end

   generate
      if (FRAC > 0) begin : g_frac
         assign acc_int = acc_q[AW-1:FRAC];
      end else begin : g_plain
         assign acc_int = acc_q;
      end
   endgenerate

   assert_acc_step_R2: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (acc_q - $past(acc_q)) == $past(n_step));

endmodule

// File: rtl/pdet_err_calc.sv
module pdet_err_calc #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] ref_int,
   input  logic [W-1:0] osc_in,
   output logic [W-1:0] err,
   output logic [W-1:0] mag
);
   logic [W-1:0] osc_q;

   always_ff @(posedge clk) begin
      if (rst) osc_q <= '0;
      else     osc_q <= osc_in;
   end

   always_comb begin
      err = ref_int - osc_q;
      mag = err[W-1] ? (~err + 1'b1) : err;
   end

   assert_err_diff_R3: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (ref_int - err) == $past(osc_in));

   assert_mag_edge_R10: assert property (@(posedge clk) disable iff (rst)
      (err == {1'b1, {(W-1){1'b0}}}) |-> (mag == err));

endmodule

// File: rtl/pdet_lock_mon.sv
module pdet_lock_mon #(
   parameter int W  = 8,
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [W-1:0]  mag,
   input  logic [W-1:0]  lock_thr,
   input  logic [W-1:0]  unlock_thr,
   input  logic [CW-1:0] lock_len,
   output logic          track_nxt,
   output logic          track,
   output logic          chg
);
   import pdet_pkg::*;

   pd_mode_e      mode_q, mode_d;
   logic [CW-1:0] run_q, run_d;
   logic [CW:0]   need;
   logic          chg_d;

   always_comb begin
      need   = (lock_len == '0) ? {{CW{1'b0}}, 1'b1} : {1'b0, lock_len};
      mode_d = mode_q;
      run_d  = run_q;
      chg_d  = 1'b0;
      if (mode_q == MODE_LINEAR) begin
         if (mag <= lock_thr) begin
            if (({1'b0, run_q} + 1'b1) >= need) begin
               mode_d = MODE_TRACK;
               run_d  = '0;
               chg_d  = 1'b1;
            end else begin
               run_d = run_q + 1'b1;
            end
         end else begin
            run_d = '0;
         end
      end else if (mag > unlock_thr) begin
         mode_d = MODE_LINEAR;
         run_d  = '0;
         chg_d  = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q <= MODE_LINEAR;
         run_q  <= '0;
         chg    <= 1'b0;
      end else begin
         mode_q <= mode_d;
         run_q  <= run_d;
         chg    <= chg_d;
      end
   end

   assign track_nxt = (mode_d == MODE_TRACK);
   assign track     = (mode_q == MODE_TRACK);

   assert_keep_track_R7: assert property (@(posedge clk) disable iff (rst)
      (track && mag <= unlock_thr) |=> track);

   assert_drop_track_R7: assert property (@(posedge clk) disable iff (rst)
      (track && mag > unlock_thr) |=> !track);

   assert_no_early_lock_R6: assert property (@(posedge clk) disable iff (rst)
      (!track && mag > lock_thr) |=> !track);

endmodule

// File: rtl/pdet_out_stage.sv
module pdet_out_stage #(
   parameter int W = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [W-1:0]        err,
   input  logic                track_nxt,
   output logic signed [W-1:0] err_out,
   output logic                err_valid
);
   localparam logic [W-1:0] PLUS_ONE  = W'(1);
   localparam logic [W-1:0] MINUS_ONE = {W{1'b1}};

   always_ff @(posedge clk) begin
      if (rst) begin
         err_out   <= '0;
         err_valid <= 1'b0;
      end else begin
         err_out   <= track_nxt ? (err[W-1] ? MINUS_ONE : PLUS_ONE) : err;
         err_valid <= 1'b1;
      end
   end

   assert_linear_pass_R4: assert property (@(posedge clk) disable iff (rst)
      (!rst && !track_nxt) |=> err_out == $past(err));

endmodule

// File: rtl/phase_det_dual.sv
module phase_det_dual #(
   parameter int W          = 12,
   parameter int PRESC_LOG2 = 2,
   parameter int CW         = 6
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [W+PRESC_LOG2-1:0]    mult_n,
   input  logic [W-1:0]               osc_count,
   input  logic [W-1:0]               lock_thr,
   input  logic [W-1:0]               unlock_thr,
   input  logic [CW-1:0]              lock_len,
   output logic signed [W-1:0]        err_out,
   output logic                       err_valid,
   output logic                       mode_track,
   output logic                       mode_chg
);
   localparam int FRAC = PRESC_LOG2;

   generate
      if (W < 4) begin : g_bad_w
         $error("phase_det_dual: W must be at least 4");
      end
      if (FRAC > 4) begin : g_bad_frac
         $error("phase_det_dual: PRESC_LOG2 must be 4 or less");
      end
      if (CW < 1) begin : g_bad_cw
         $error("phase_det_dual: CW must be at least 1");
      end
   endgenerate

   logic [W-1:0] ref_int;
   logic [W-1:0] err_raw;
   logic [W-1:0] err_mag;
   logic         trk_nxt;

   pdet_ref_acc #(.W(W), .FRAC(FRAC)) u_ref (
      .clk    (clk),
      .rst    (rst),
      .n_step (mult_n),
      .acc_int(ref_int)
   );

   pdet_err_calc #(.W(W)) u_err (
      .clk    (clk),
      .rst    (rst),
      .ref_int(ref_int),
      .osc_in (osc_count),
      .err    (err_raw),
      .mag    (err_mag)
   );

   pdet_lock_mon #(.W(W), .CW(CW)) u_lock (
      .clk       (clk),
      .rst       (rst),
      .mag       (err_mag),
      .lock_thr  (lock_thr),
      .unlock_thr(unlock_thr),
      .lock_len  (lock_len),
      .track_nxt (trk_nxt),
      .track     (mode_track),
      .chg       (mode_chg)
   );

   pdet_out_stage #(.W(W)) u_out (
      .clk      (clk),
      .rst      (rst),
      .err      (err_raw),
      .track_nxt(trk_nxt),
      .err_out  (err_out),
      .err_valid(err_valid)
   );

   assert_chg_pulse_R8: assert property (@(posedge clk) disable iff (rst)
      mode_chg |-> (mode_track != $past(mode_track)));

   assert_sign_only_R5: assert property (@(posedge clk) disable iff (rst)
      (mode_track && err_valid) |-> (err_out == 1 || err_out == -1));

   assert_valid_R9: assert property (@(posedge clk) disable iff (rst)
      !rst |=> err_valid);

endmodule

// File: tb/phase_det_dual_test.sv
module phase_det_dual_test;
   localparam int W  = 8;
   localparam int FR = 2;
   localparam int CW = 4;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic                rst;
   logic [W+FR-1:0]     mult_n;
   logic [W-1:0]        osc_count;
   logic [W-1:0]        lock_thr;
   logic [W-1:0]        unlock_thr;
   logic [CW-1:0]       lock_len;
   logic signed [W-1:0] err_out;
   logic                err_valid;
   logic                mode_track;
   logic                mode_chg;

   phase_det_dual #(.W(W), .PRESC_LOG2(FR), .CW(CW)) uut (
      .clk(clk), .rst(rst), .mult_n(mult_n), .osc_count(osc_count),
      .lock_thr(lock_thr), .unlock_thr(unlock_thr), .lock_len(lock_len),
      .err_out(err_out), .err_valid(err_valid), .mode_track(mode_track),
      .mode_chg(mode_chg)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [W+FR-1:0]     m_acc;
   logic [W-1:0]        m_osc;
   logic                m_trk;
   int                  m_cnt;
   logic signed [W-1:0] e_err;
   logic                e_valid;
   logic                e_chg;

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // Advance one reference cycle, model it from the requirements, compare.
   task automatic step(string tag);
      logic [W-1:0] ri;
      logic [W-1:0] d;
      int mag;
      int len;
      logic nt;
      logic c;
      @(posedge clk);
      if (rst) begin
         m_acc = '0; m_osc = '0; m_trk = 1'b0; m_cnt = 0;
         e_err = '0; e_valid = 1'b0; e_chg = 1'b0;
      end else begin
         ri  = m_acc[W+FR-1:FR];
         d   = ri - m_osc;
         mag = d[W-1] ? ((1 << W) - int'(d)) : int'(d);
         len = (lock_len == 0) ? 1 : int'(lock_len);
         nt  = m_trk;
         c   = 1'b0;
         if (!m_trk) begin
            if (mag <= int'(lock_thr)) begin
               if (m_cnt + 1 >= len) begin nt = 1'b1; m_cnt = 0; c = 1'b1; end
               else m_cnt++;
            end else m_cnt = 0;
         end else if (mag > int'(unlock_thr)) begin
            nt = 1'b0; m_cnt = 0; c = 1'b1;
         end
         e_err   = nt ? (d[W-1] ? -8'sd1 : 8'sd1) : $signed(d);
         m_trk   = nt;
         e_chg   = c;
         e_valid = 1'b1;
         m_acc   = m_acc + mult_n;
         m_osc   = osc_count;
      end
      @(negedge clk);
      if (rst) begin
         chk("R1", int'(err_out), 0);
         chk("R1", int'(err_valid), 0);
         chk("R1", int'(mode_track), 0);
         chk("R1", int'(mode_chg), 0);
      end else begin
         chk("R9", int'(err_valid), int'(e_valid));
         if (m_trk) chk("R5", int'(err_out), int'(e_err));
         else       chk(tag, int'(err_out), int'(e_err));
         chk(m_trk ? "R7" : "R6", int'(mode_track), int'(m_trk));
         chk("R8", int'(mode_chg), int'(e_chg));
      end
   endtask

   // Set osc_count so the error evaluated two edges later equals d.
   task automatic aim(int d, string tag);
      logic [W+FR-1:0] nxt;
      nxt = m_acc + mult_n;
      osc_count = nxt[W+FR-1:FR] - W'(d);
      step(tag);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int nlist [4] = '{5, 7, 13, 1023};
      rst = 1'b1; mult_n = '0; osc_count = '0;
      lock_thr = '0; unlock_thr = 8'd255; lock_len = 4'd15;
      @(negedge clk);
      step("R1");
      step("R1");

      // R2: osc held at zero, the error is the accumulator integer part.
      rst = 1'b0; mult_n = 10'd7; lock_len = 4'd15; lock_thr = '0;
      for (int i = 0; i < 30; i++) step("R2");

      // R3 / R4: sweep of N values with arbitrary oscillator counts.
      foreach (nlist[j]) begin
         mult_n = 10'(nlist[j]);
         for (int i = 0; i < 40; i++) begin
            osc_count = 8'($urandom_range(0, 255));
            step(nlist[j] == 1023 ? "R10" : "R3");
         end
      end

      // R1: reset in the middle of operation.
      rst = 1'b1; step("R1"); step("R1");
      rst = 1'b0;

      // R6 / R7 / R8 / R5: lock, hysteresis, unlock.
      mult_n = 10'd16; lock_thr = 8'd2; unlock_thr = 8'd6; lock_len = 4'd5;
      for (int i = 0; i < 3; i++) aim(0, "R4");
      aim(3, "R6");
      for (int i = 0; i < 8; i++) aim((i % 2) ? 2 : -2, "R6");
      aim(5, "R7");
      aim(-6, "R7");
      aim(-6, "R5");
      aim(7, "R7");
      aim(7, "R7");
      for (int i = 0; i < 3; i++) aim(1, "R4");
      aim(-7, "R7");
      aim(0, "R4");

      // R6: lock_len of zero acts as one.
      lock_len = 4'd0;
      aim(20, "R4"); aim(20, "R4");
      aim(0, "R6"); aim(0, "R6"); aim(-1, "R5"); aim(-1, "R5");

      // R10: extreme magnitudes with wrapped counters.
      lock_thr = '0; unlock_thr = 8'd127; lock_len = 4'd15;
      mult_n = 10'd1023;
      aim(-128, "R10"); aim(-128, "R10"); aim(127, "R10"); aim(-127, "R10");
      aim(0, "R10"); aim(100, "R10"); aim(-100, "R10");
      for (int i = 0; i < 20; i++) aim(int'($urandom_range(0, 255)) - 128, "R10");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule